// File: doc/BRIEF.md
# Knockout Cell Concentrator

This block sits in front of one output port of a cell switch. Up to N cells that all target that port can arrive in the same cycle, each with a valid flag, a data word and an implicit source number (its input position). The output side has only L lanes, L smaller than N. The block chooses which cells go to the lanes and marks the rest as discarded through a per-input drop vector. Outputs are combinational: a cell presented in a cycle is either on a lane or flagged dropped in that same cycle.

Selection runs as a chain of L divisions. Each division is a binary tree of two-input contention elements and has N inputs. The tree root's winner fills that division's lane. Every element also yields a loser, and the losers of division k become the inputs of division k+1, which contests the next lane. The losers of the last division are discarded. Each element holds one preference bit, and this bit is the only state in the block. The bit is a two-state machine with states PREF_LO (the lower-numbered side wins a contest) and PREF_HI (the higher-numbered side wins). Its transition FLIP is taken after each cycle in which both sides held a valid cell. Its transition HOLD is taken in every other cycle. Reset places every element in PREF_LO.

N must be a power of two. The defaults are N=8, L=4 and 8-bit data.

Top module: `knockout_concentrator`

## Requirements
- R1: The number of valid output lanes in a cycle equals the number of valid inputs, limited to L.
- R2: Lanes fill upward from lane 0 with no gaps, so out_valid is always of the form 2^m-1.
- R3: Each valid lane k carries on out_src (bits k*IW+IW-1..k*IW, IW=log2 N) the number of a valid input, and its data equals that input's data. No input appears on two lanes.
- R4: drop bit i is 1 exactly when input i is valid and appears on no lane. An invalid input is never dropped and never forwarded.
- R5: In a contention element where only one side holds a valid cell, that cell wins and the loser output is invalid. A lone valid input at any position therefore appears on lane 0.
- R6: In a contention element where both sides are valid, the left (lower-numbered) side wins in PREF_LO and the right side wins in PREF_HI. The state flips after each contested cycle and holds otherwise. With only inputs 0 and 1 valid from reset, lane 0 carries 0, 1, 0, 1, ... on successive cycles, and an idle or uncontested cycle leaves the order unchanged.
- R7: Tree nodes are numbered breadth-first from the root at 0. Node i has children 2i+1 (left) and 2i+2 (right), and input j sits at leaf N-1+j. The loser of node i becomes input i of the next division, and input N-1 of that division is empty. With all eight inputs valid in the first cycle after reset, lanes 0..3 carry sources 0, 4, 3, 1 and drop equals 8'hE4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; preference bits update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; all elements to PREF_LO |
| in_valid | input | N | Per-input cell present flag |
| in_data | input | N*W | Per-input data word, input i at bits i*W+W-1..i*W |
| out_valid | output | L | Per-lane cell present flag |
| out_data | output | L*W | Per-lane data word |
| out_src | output | L*IW | Per-lane source input number |
| drop | output | N | Per-input discard flag for the current cycle |

## Verification
Every cycle, the assertions check the lane count, the gap-free lane fill, that each lane's data matches the data of its source input, and that the drop vector equals the set of cells left over after the last division. Inside every element they also check the lone-winner rule and the FLIP/HOLD transitions. Which particular cell wins depends on the history of all the preference bits, so only the bench's directed scenarios show the exact winners. These are the alternation of two contending inputs across idle and uncontested cycles, the lane-0 sweep of a lone input, and the full-load lane order after reset that depends on the loser wiring between divisions.

// File: rtl/kc_pkg.sv
package kc_pkg;

    // Preference state of one contention element.
    typedef enum logic {
        PREF_LO = 1'b0,   // left (lower-numbered) side wins a contest
        PREF_HI = 1'b1    // right (higher-numbered) side wins a contest
    } pref_e;

endpackage

// File: rtl/kc_contend.sv
module kc_contend
    import kc_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_v,
    input  logic [W-1:0]  a_d,
    input  logic [IW-1:0] a_s,
    input  logic          b_v,
    input  logic [W-1:0]  b_d,
    input  logic [IW-1:0] b_s,
    output logic          w_v,
    output logic [W-1:0]  w_d,
    output logic [IW-1:0] w_s,
    output logic          l_v,
    output logic [W-1:0]  l_d,
    output logic [IW-1:0] l_s
);

    pref_e pref_q;
    pref_e pref_d;
    logic  contested;
    logic  take_b;

    assign contested = a_v & b_v;

    // Next-state logic: FLIP on a contested cycle, HOLD otherwise.
    always_comb begin
        pref_d = pref_q;
        unique case (pref_q)
            PREF_LO: pref_d = contested ? PREF_HI : PREF_LO;
            PREF_HI: pref_d = contested ? PREF_LO : PREF_HI;
            default: pref_d = PREF_LO;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pref_q <= PREF_LO;
        end else begin
            pref_q <= pref_d;
        end
    end

    // Output logic: a lone valid cell always wins; a contest follows the state.
    always_comb begin
        take_b = b_v & (~a_v | (pref_q == PREF_HI));
        if (take_b) begin
            w_v = b_v;  w_d = b_d;  w_s = b_s;
            l_v = a_v;  l_d = a_d;  l_s = a_s;
        end else begin
            w_v = a_v;  w_d = a_d;  w_s = a_s;
            l_v = b_v;  l_d = b_d;  l_s = b_s;
        end
    end

    // R5: a single valid side wins and the loser is empty.
    a_r5_lone_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (a_v ^ b_v) |-> (w_v && !l_v && (w_s == (a_v ? a_s : b_s))));

    // R6: a contest forwards both cells, winner chosen by the state.
    a_r6_contest_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (a_v && b_v) |-> (w_v && l_v && (w_s == ((pref_q == PREF_HI) ? b_s : a_s))));

    // R6: FLIP after a contested cycle.
    a_r6_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (a_v && b_v) |=> (pref_q != $past(pref_q)));

    // R6: HOLD when not contested.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_v && b_v) |=> $stable(pref_q));

endmodule

// File: rtl/kc_division.sv
module kc_division #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    in_v,
    input  logic [N*W-1:0]  in_d,
    input  logic [N*IW-1:0] in_s,
    output logic            win_v,
    output logic [W-1:0]    win_d,
    output logic [IW-1:0]   win_s,
    output logic [N-1:0]    lose_v,
    output logic [N*W-1:0]  lose_d,
    output logic [N*IW-1:0] lose_s
);

    localparam int NODES = 2 * N - 1;
    localparam int INNER = N - 1;

    // Heap-ordered tree: node i has children 2i+1 and 2i+2, leaves at N-1+j.
    logic          nd_v [NODES];
    logic [W-1:0]  nd_d [NODES];
    logic [IW-1:0] nd_s [NODES];

    for (genvar j = 0; j < N; j++) begin : g_leaf
        assign nd_v[INNER + j] = in_v[j];
        assign nd_d[INNER + j] = in_d[j*W +: W];
        assign nd_s[INNER + j] = in_s[j*IW +: IW];
    end

    for (genvar i = 0; i < INNER; i++) begin : g_elem
        kc_contend #(
            .W  (W),
            .IW (IW)
        ) u_elem (
            .clk   (clk),
            .rst_n (rst_n),
            .a_v   (nd_v[2*i+1]),
            .a_d   (nd_d[2*i+1]),
            .a_s   (nd_s[2*i+1]),
            .b_v   (nd_v[2*i+2]),
            .b_d   (nd_d[2*i+2]),
            .b_s   (nd_s[2*i+2]),
            .w_v   (nd_v[i]),
            .w_d   (nd_d[i]),
            .w_s   (nd_s[i]),
            .l_v   (lose_v[i]),
            .l_d   (lose_d[i*W +: W]),
            .l_s   (lose_s[i*IW +: IW])
        );
    end

    // The last loser slot has no element behind it and stays empty.
    assign lose_v[N-1]             = 1'b0;
    assign lose_d[(N-1)*W +: W]    = '0;
    assign lose_s[(N-1)*IW +: IW]  = '0;

    assign win_v = nd_v[0];
    assign win_d = nd_d[0];
    assign win_s = nd_s[0];

    // R1: the division produces a winner whenever any input is valid,
    // and passes every other valid cell on as a loser.
    a_r1_div_conserve: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(in_v) == ($countones(lose_v) + (win_v ? 1 : 0))));

endmodule

// File: rtl/knockout_concentrator.sv
module knockout_concentrator #(
    parameter int N  = 8,
    parameter int L  = 4,
    parameter int W  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    in_valid,
    input  logic [N*W-1:0]  in_data,
    output logic [L-1:0]    out_valid,
    output logic [L*W-1:0]  out_data,
    output logic [L*IW-1:0] out_src,
    output logic [N-1:0]    drop
);

    // Cell sets passed between divisions; set 0 is the block input.
    logic [N-1:0]    ch_v [L+1];
    logic [N*W-1:0]  ch_d [L+1];
    logic [N*IW-1:0] ch_s [L+1];
    logic [N-1:0]    fwd;
    logic [N-1:0]    lost_mask;

    assign ch_v[0] = in_valid;
    assign ch_d[0] = in_data;

    for (genvar j = 0; j < N; j++) begin : g_src
        assign ch_s[0][j*IW +: IW] = IW'(j);
    end

    for (genvar k = 0; k < L; k++) begin : g_div
        kc_division #(
            .N  (N),
            .W  (W),
            .IW (IW)
        ) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_v   (ch_v[k]),
            .in_d   (ch_d[k]),
            .in_s   (ch_s[k]),
            .win_v  (out_valid[k]),
            .win_d  (out_data[k*W +: W]),
            .win_s  (out_src[k*IW +: IW]),
            .lose_v (ch_v[k+1]),
            .lose_d (ch_d[k+1]),
            .lose_s (ch_s[k+1])
        );
    end

    // Inputs that reached a lane.
    always_comb begin
        fwd = '0;
        for (int k = 0; k < L; k++) begin
            if (out_valid[k]) begin
                fwd[out_src[k*IW +: IW]] = 1'b1;
            end
        end
    end

    assign drop = in_valid & ~fwd;

    // Cells left over after the last division, by source.
    always_comb begin
        lost_mask = '0;
        for (int j = 0; j < N; j++) begin
            if (ch_v[L][j]) begin
                lost_mask[ch_s[L][j*IW +: IW]] = 1'b1;
            end
        end
    end

    // R1: lane count is the valid count limited to L.
    a_r1_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_valid) ==
            (($countones(in_valid) > L) ? L : $countones(in_valid)));

    // R2: no gap in the lane fill.
    for (genvar k = 0; k < L - 1; k++) begin : g_chk_gap
        a_r2_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k+1] |-> out_valid[k]);
    end

    // R3: lane data matches the data of its valid source input.
    for (genvar k = 0; k < L; k++) begin : g_chk_lane
        a_r3_lane_data: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k] |-> (in_valid[out_src[k*IW +: IW]] &&
                (out_data[k*W +: W] == in_data[out_src[k*IW +: IW]*W +: W])));
    end

    // R3: discarded cells still carry their own input's data.
    for (genvar j = 0; j < N; j++) begin : g_chk_lost
        a_r3_discard_data: assert property (@(posedge clk) disable iff (!rst_n)
            ch_v[L][j] |->
                (ch_d[L][j*W +: W] == in_data[ch_s[L][j*IW +: IW]*W +: W]));
    end

    // R4: drop names exactly the cells the last division discarded.
    a_r4_drop_is_discard: assert property (@(posedge clk) disable iff (!rst_n)
        drop == lost_mask);

    // R4: an invalid input is never dropped.
    a_r4_drop_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (drop & ~in_valid) == '0);

endmodule

// File: tb/knockout_concentrator_bench.sv
module knockout_concentrator_bench;

    localparam int N  = 8;
    localparam int L  = 4;
    localparam int W  = 8;
    localparam int IW = 3;
    localparam int NV = 10;

    // Stimulus table and expected lane count (R1).
    localparam logic [N-1:0] VEC_IN [NV] = '{
        8'h00, 8'h01, 8'h80, 8'h18, 8'h07, 8'h0F, 8'h1F, 8'hFF, 8'hA5, 8'h7E };
    localparam int VEC_CNT [NV] = '{ 0, 1, 1, 2, 3, 4, 4, 4, 4, 4 };

    logic            clk;
    logic            rst_n;
    logic [N-1:0]    in_valid;
    logic [N*W-1:0]  in_data;
    logic [L-1:0]    out_valid;
    logic [L*W-1:0]  out_data;
    logic [L*IW-1:0] out_src;
    logic [N-1:0]    drop;

    int total = 0;
    int bad   = 0;

    knockout_concentrator #(
        .N (N), .L (L), .W (W), .IW (IW)
    ) u_knockout_concentrator (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_src   (out_src),
        .drop      (drop)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int src_of(input int k);
        return int'(out_src[k*IW +: IW]);
    endfunction

    // Apply one cycle of stimulus and let the combinational outputs settle.
    task automatic apply(input logic [N-1:0] v);
        @(negedge clk);
        in_valid = v;
        #2;
    endtask

    task automatic do_reset;
        @(negedge clk);
        in_valid = '0;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Requirement-level checks valid for any preference history.
    task automatic check_general(input int exp_cnt);
        logic [N-1:0] seen;
        int cnt;
        bit distinct;
        bit data_ok;
        seen = '0;
        distinct = 1'b1;
        data_ok = 1'b1;
        cnt = $countones(out_valid);
        chk(cnt == exp_cnt, "R1", "lane count", cnt, exp_cnt);
        chk(out_valid == L'((1 << exp_cnt) - 1), "R2", "lane fill",
            int'(out_valid), (1 << exp_cnt) - 1);
        for (int k = 0; k < L; k++) begin
            if (out_valid[k]) begin
                if (seen[src_of(k)] || !in_valid[src_of(k)]) distinct = 1'b0;
                seen[src_of(k)] = 1'b1;
                if (out_data[k*W +: W] != (8'hA0 | 8'(src_of(k)))) data_ok = 1'b0;
            end
        end
        chk(distinct, "R3", "distinct valid sources", int'(seen), int'(in_valid));
        chk(data_ok, "R3", "lane data", int'(out_data), 0);
        chk(drop == (in_valid & ~seen), "R4", "drop vector",
            int'(drop), int'(in_valid & ~seen));
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = '0;
        for (int i = 0; i < N; i++) in_data[i*W +: W] = 8'hA0 | 8'(i);

        // Reset state.
        #5;
        chk(out_valid == '0, "R1", "reset lanes", int'(out_valid), 0);
        chk(drop == '0, "R4", "reset drop", int'(drop), 0);
        do_reset();

        // Table walk: each vector held for two cycles.
        for (int t = 0; t < NV; t++) begin
            for (int r = 0; r < 2; r++) begin
                apply(VEC_IN[t]);
                check_general(VEC_CNT[t]);
            end
        end

        // R5: lone valid input at every position lands on lane 0.
        for (int i = 0; i < N; i++) begin
            apply(N'(1) << i);
            chk(out_valid == L'(1), "R5", "lone lane valid", int'(out_valid), 1);
            chk(src_of(0) == i, "R5", "lone source", src_of(0), i);
            chk(drop == '0, "R5", "lone no drop", int'(drop), 0);
        end

        // R7: full load directly after reset.
        do_reset();
        apply(8'hFF);
        check_general(L);
        chk(src_of(0) == 0, "R7", "lane0 source", src_of(0), 0);
        chk(src_of(1) == 4, "R7", "lane1 source", src_of(1), 4);
        chk(src_of(2) == 3, "R7", "lane2 source", src_of(2), 3);
        chk(src_of(3) == 1, "R7", "lane3 source", src_of(3), 1);
        chk(drop == 8'hE4, "R7", "drop after full load", int'(drop), 8'hE4);

        // R6: two contenders alternate on lane 0.
        do_reset();
        for (int c = 0; c < 6; c++) begin
            apply(8'h03);
            check_general(2);
            chk(src_of(0) == (c % 2), "R6", "alternate lane0", src_of(0), c % 2);
            chk(src_of(1) == 1 - (c % 2), "R6", "alternate lane1", src_of(1), 1 - (c % 2));
        end

        // R6: idle and uncontested cycles hold the preference.
        do_reset();
        apply(8'h03);
        chk(src_of(0) == 0, "R6", "first contest", src_of(0), 0);
        apply(8'h00);
        chk(out_valid == '0, "R6", "idle lanes", int'(out_valid), 0);
        apply(8'h03);
        chk(src_of(0) == 1, "R6", "after idle", src_of(0), 1);
        apply(8'h01);
        chk(src_of(0) == 0, "R6", "uncontested", src_of(0), 0);
        apply(8'h03);
        chk(src_of(0) == 0, "R6", "after uncontested", src_of(0), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule